// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a word or byte load or store, and the value to write back into the base register. It takes the base register value, a second register value usable as an index, and the addressing fields of the instruction. The offset is either a 12-bit unsigned constant or the index register shifted by a constant amount. The offset is then added to or subtracted from the base.

The indexing mode decides which value goes out as the address. With pre-indexing the access goes to base±offset, and the base is updated only when writeback is asked for. With post-indexing the access goes to the unmodified base, and the base is always updated to base±offset. All results are registered. A valid input yields one result one clock later, and a new input can be taken on every cycle.

Top module: `ls_addr_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_wb_en`, `out_addr` and `out_wb_data` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and is low after a cycle with `in_valid` low.
- R3: When `in_reg_off` is 0, the offset is `in_ofs_field[11:0]`, zero-extended to the data width. Values up to 4095 are used as they are.
- R4: When `in_reg_off` is 1, the shift amount is `in_ofs_field[11:7]` and the shift kind is `in_ofs_field[6:5]`. Kind 00 shifts `in_index` left, and an amount of 0 passes it unchanged.
- R5: Kind 01 is a logical right shift of `in_index`. An amount of 0 means a shift by 32, which gives 0.
- R6: Kind 10 is an arithmetic right shift of `in_index`. An amount of 0 gives every bit equal to bit 31 of `in_index`.
- R7: Kind 11 rotates `in_index` right. An amount of 0 passes it unchanged.
- R8: With `in_up` at 1 the offset is added to `in_base`. With `in_up` at 0 it is subtracted. Both wrap modulo 2^32.
- R9: With `in_pre` at 1, `out_addr` and `out_wb_data` both equal base±offset, and `out_wb_en` equals `in_wb`.
- R10: With `in_pre` at 0, `out_addr` equals the unmodified `in_base`, `out_wb_data` equals base±offset, and `out_wb_en` is 1 whatever the value of `in_wb`.
- R11: Inputs on consecutive cycles each produce their own result on the following cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| in_reg_off | input | 1 | 1: shifted register offset, 0: constant offset |
| in_pre | input | 1 | 1: index before access, 0: after access |
| in_up | input | 1 | 1: add offset, 0: subtract offset |
| in_wb | input | 1 | Writeback request for pre-indexing |
| in_ofs_field | input | 12 | Constant offset, or shift amount [11:7] and kind [6:5] |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective access address |
| out_wb_data | output | 32 | Value for the base register |
| out_wb_en | output | 1 | Base register update enable |

## Verification
On every cycle the assertions check the one-cycle valid timing and the mode relations. For post-indexing they check that the address repeats the earlier base and that writeback is forced on. For pre-indexing they check that the address and the writeback value agree and that the enable follows the request. The actual offset arithmetic cannot be checked that way. That covers the zero extension of the constant, each shift kind with its amount-zero case, add against subtract, and wraparound. Only the bench scenarios, compared against an independent model, can show these.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
    localparam int OFS_FIELD_W = 12;
    localparam int SH_AMT_LSB  = 7;
    localparam int SH_KIND_LSB = 5;

    typedef enum logic [1:0] {
        SHK_LEFT   = 2'b00,
        SHK_RIGHT  = 2'b01,
        SHK_ARITH  = 2'b10,
        SHK_ROTATE = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
    import lsag_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int SHAMT_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]    val_i,
    input  shift_kind_e        kind_i,
    input  logic [SHAMT_W-1:0] amt_i,
    output logic [XLEN-1:0]    res_o
);
    logic [2*XLEN-1:0] doubled;
    logic [2*XLEN-1:0] rot_full;
    logic              amt_zero;

    assign doubled  = {val_i, val_i};
    assign rot_full = doubled >> amt_i;
    assign amt_zero = (amt_i == '0);

    always_comb begin
        res_o = val_i;
        unique case (kind_i)
            SHK_LEFT:   res_o = val_i << amt_i;
            SHK_RIGHT:  res_o = amt_zero ? '0 : (val_i >> amt_i);
            SHK_ARITH:  res_o = amt_zero ? {XLEN{val_i[XLEN-1]}}
                                         : XLEN'($signed(val_i) >>> amt_i);
            SHK_ROTATE: res_o = rot_full[XLEN-1:0];
            default:    res_o = val_i;
        endcase
    end
endmodule

// File: rtl/lsag_offset.sv
module lsag_offset
    import lsag_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int FIELD_W = OFS_FIELD_W,
    parameter int SHAMT_W = $clog2(XLEN)
) (
    input  logic               reg_off_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [XLEN-1:0]    index_i,
    output logic [XLEN-1:0]    offset_o
);
    logic [XLEN-1:0]    shifted;
    logic [XLEN-1:0]    const_ofs;
    logic [SHAMT_W-1:0] amt;
    shift_kind_e        kind;

    assign amt       = field_i[SH_AMT_LSB +: SHAMT_W];
    assign kind      = shift_kind_e'(field_i[SH_KIND_LSB +: 2]);
    assign const_ofs = XLEN'(field_i);

    lsag_shifter #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_shift (
        .val_i  (index_i),
        .kind_i (kind),
        .amt_i  (amt),
        .res_o  (shifted)
    );

    assign offset_o = reg_off_i ? shifted : const_ofs;
endmodule

// File: rtl/lsag_sum.sv
module lsag_sum #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] offset_i,
    input  logic            up_i,
    output logic [XLEN-1:0] sum_o
);
    assign sum_o = up_i ? (base_i + offset_i) : (base_i - offset_i);
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import lsag_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int FIELD_W = OFS_FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_reg_off,
    input  logic               in_pre,
    input  logic               in_up,
    input  logic               in_wb,
    input  logic [FIELD_W-1:0] in_ofs_field,
    input  logic [XLEN-1:0]    in_base,
    input  logic [XLEN-1:0]    in_index,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_addr,
    output logic [XLEN-1:0]    out_wb_data,
    output logic               out_wb_en
);
    localparam int SHAMT_W = $clog2(XLEN);

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wbd;
        logic            wbe;
    } res_t;

    res_t            res_d, res_q;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] moved;

    lsag_offset #(.XLEN(XLEN), .FIELD_W(FIELD_W), .SHAMT_W(SHAMT_W)) u_ofs (
        .reg_off_i (in_reg_off),
        .field_i   (in_ofs_field),
        .index_i   (in_index),
        .offset_o  (offset)
    );

    lsag_sum #(.XLEN(XLEN)) u_sum (
        .base_i   (in_base),
        .offset_i (offset),
        .up_i     (in_up),
        .sum_o    (moved)
    );

    // Next-state: pre-indexing sends the moved base out, post-indexing the original.
    always_comb begin
        res_d      = res_q;
        res_d.vld  = in_valid;
        if (in_valid) begin
            res_d.addr = in_pre ? moved : in_base;
            res_d.wbd  = moved;
            res_d.wbe  = in_pre ? in_wb : 1'b1;
        end else begin
            res_d.wbe  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.vld;
    assign out_addr    = res_q.addr;
    assign out_wb_data = res_q.wbd;
    assign out_wb_en   = res_q.wbe;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_pre_addr_matches_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pre) |=> (out_addr == out_wb_data));
    assert_pre_wb_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pre) |=> (out_wb_en == $past(in_wb)));
    assert_post_addr_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_pre) |=> (out_addr == $past(in_base)));
    assert_post_wb_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_pre) |=> out_wb_en);
endmodule

// File: tb/ls_addr_gen_tb.sv
`timescale 1ns/1ps
module ls_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_reg_off = 1'b0;
    logic        in_pre = 1'b0;
    logic        in_up = 1'b0;
    logic        in_wb = 1'b0;
    logic [11:0] in_ofs_field = '0;
    logic [31:0] in_base = '0;
    logic [31:0] in_index = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_wb_data;
    logic        out_wb_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] q_addr[$];
    logic [31:0] q_wbd[$];
    logic        q_wbe[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    ls_addr_gen u_dut (
        .clk, .rst_n, .in_valid, .in_reg_off, .in_pre, .in_up, .in_wb,
        .in_ofs_field, .in_base, .in_index,
        .out_valid, .out_addr, .out_wb_data, .out_wb_en
    );

    function automatic logic [31:0] model_shift(logic [31:0] v, logic [1:0] k, int a);
        logic [31:0] r;
        case (k)
            2'b00: r = v << a;
            2'b01: r = (a == 0) ? 32'h0 : (v >> a);
            2'b10: r = (a == 0) ? {32{v[31]}} : 32'($signed(v) >>> a);
            default: r = (a == 0) ? v : ((v >> a) | (v << (32 - a)));
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic drive(string tag, bit rof, bit pre, bit up, bit wb,
                         logic [11:0] fld, logic [31:0] base, logic [31:0] idx);
        logic [31:0] ofs, mv;
        @(negedge clk);
        in_valid = 1; in_reg_off = rof; in_pre = pre; in_up = up; in_wb = wb;
        in_ofs_field = fld; in_base = base; in_index = idx;
        ofs = rof ? model_shift(idx, fld[6:5], int'(fld[11:7])) : {20'h0, fld};
        mv  = up ? base + ofs : base - ofs;
        q_addr.push_back(pre ? mv : base);
        q_wbd.push_back(mv);
        q_wbe.push_back(pre ? wb : 1'b1);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    // Monitor: scoreboard pops one expected item per valid result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_addr.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 unexpected valid got=1 exp=0");
            end else begin
                string t;
                t = q_tag.pop_front();
                check(t, out_addr, q_addr.pop_front(), "addr");
                check(t, out_wb_data, q_wbd.pop_front(), "wb_data");
                check(t, {31'h0, out_wb_en}, {31'h0, q_wbe.pop_front()}, "wb_en");
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {31'h0, out_valid}, 32'h0, "valid in reset");
        check("R1", out_addr, 32'h0, "addr in reset");
        check("R1", {31'h0, out_wb_en}, 32'h0, "wb_en in reset");
        rst_n = 1;

        // R3 constant offsets, R8 add/subtract, R9 pre-indexing
        drive("R3", 0, 1, 1, 0, 12'd25, 32'h0000_1000, 32'h0);
        drive("R3", 0, 1, 1, 1, 12'hFFF, 32'h0000_0010, 32'hFFFF_FFFF);
        drive("R8", 0, 1, 0, 1, 12'd8, 32'h0000_0004, 32'h0);
        drive("R9", 0, 1, 0, 0, 12'd16, 32'h8000_0000, 32'h0);
        idle();
        @(negedge clk);
        check("R2", {31'h0, out_valid}, 32'h0, "valid after idle");
        // R10 post-indexing, writeback forced whatever in_wb is
        drive("R10", 0, 0, 1, 0, 12'd25, 32'h0000_2000, 32'h0);
        drive("R10", 0, 0, 0, 1, 12'd4, 32'h0000_2000, 32'h0);
        // R4 left shifts
        drive("R4", 1, 1, 1, 0, {5'd2, 2'b00, 5'd0}, 32'h100, 32'h0000_0003);
        drive("R4", 1, 1, 1, 1, {5'd0, 2'b00, 5'd3}, 32'h100, 32'h1234_5678);
        // R5 logical right
        drive("R5", 1, 1, 1, 0, {5'd4, 2'b01, 5'd0}, 32'h0, 32'hF000_0000);
        drive("R5", 1, 0, 1, 1, {5'd0, 2'b01, 5'd0}, 32'h44, 32'hFFFF_FFFF);
        // R6 arithmetic right
        drive("R6", 1, 1, 1, 0, {5'd8, 2'b10, 5'd0}, 32'h0, 32'h8000_0000);
        drive("R6", 1, 1, 1, 0, {5'd0, 2'b10, 5'd0}, 32'h10, 32'h8000_0001);
        drive("R6", 1, 1, 1, 0, {5'd0, 2'b10, 5'd0}, 32'h10, 32'h7FFF_FFFF);
        // R7 rotate right
        drive("R7", 1, 1, 1, 0, {5'd8, 2'b11, 5'd0}, 32'h0, 32'h1234_5678);
        drive("R7", 1, 0, 0, 0, {5'd0, 2'b11, 5'd0}, 32'h0, 32'h0000_0001);
        // R8 wraparound both ways; R11 back-to-back stream above
        drive("R8", 0, 1, 0, 0, 12'd1, 32'h0, 32'h0);
        drive("R11", 1, 1, 1, 0, {5'd31, 2'b00, 5'd0}, 32'hFFFF_FFFF, 32'h1);
        idle();
        @(negedge clk);
        check("R2", {31'h0, out_valid}, 32'h0, "valid after stream");
        check("R11", 32'(q_addr.size()), 32'h0, "pending results");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule